// File: doc/BRIEF.md
# Closed-Loop Voltage Trim Controller

This block is the digital half of a supply-trim loop. It steers an 8-bit trim DAC code so that a 12-bit ADC reading of a regulator's output voltage converges on a target. The target is the active setpoint. A host picks a voltage identification (VID) code, and a strobe latches the matching entry of a computed target table into a setpoint register. Alternatively, a 2-bit selector can choose one of two configured profile setpoints.

A prescaler paces the loop. On each update tick, the block compares the newest ADC sample captured since the previous tick with the active setpoint. The result has three states, and the DAC code moves by exactly one step up, one step down, or not at all. A polarity bit sets which way the code must move to raise the voltage. A bypass bit takes the code away from the loop and drives a configured value instead. When a new VID code is strobed in, the loop moves toward it without any further action from the host.

Top module: `vtrim_loop`

## Requirements
- R1: After reset, dac_code is 0x80, the VID setpoint register is 0 and the active setpoint is 0, so with prof_sel=00 an ADC reading of 0 causes no step.
- R2: The VID table entry for code c is 0x400 + 0x20*c. It is loaded into the VID setpoint register only on a cycle with vid_strobe high, and a code change without a strobe has no effect on the loop.
- R3: The prof_sel value picks the active setpoint one cycle after it is applied: 00 picks the VID setpoint register, 01 picks cfg_profile1, 10 picks cfg_profile2.
- R4: With prof_sel=11 the active setpoint keeps its last value, even if the profile inputs change.
- R5: Update ticks occur every RATE_UNIT<<cfg_rate cycles, which is 4, 8, 16 or 32 cycles by default. dac_code changes only on the clock edge of a tick.
- R6: At a tick, a sample below the setpoint calls for raising the voltage, a sample above it calls for lowering it, and an equal sample holds the code. The code moves by exactly one LSB per tick.
- R7: With cfg_invert=0, raising the voltage increments the code. With cfg_invert=1, raising the voltage decrements it.
- R8: dac_code saturates at 0x00 and 0xFF and never wraps.
- R9: A tick with no adc_valid since the previous tick leaves the code unchanged. A sample marked valid in a tick cycle is used at the following tick.
- R10: While cfg_bypass is 1, dac_code equals cfg_bypass_code one cycle later. When bypass is released, the loop steps on from that value.
- R11: After a strobe of a new VID code, the code keeps stepping toward the new target at each tick with no further host action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_code | input | VID_W | VID table index |
| vid_strobe | input | 1 | Loads the indexed table entry into the VID setpoint |
| prof_sel | input | 2 | Setpoint source select |
| cfg_profile1 | input | 12 | Profile setpoint for select 01 |
| cfg_profile2 | input | 12 | Profile setpoint for select 10 |
| cfg_rate | input | 2 | Update-rate select |
| cfg_invert | input | 1 | Polarity: 1 means decrement raises the voltage |
| cfg_bypass | input | 1 | Open the loop and drive cfg_bypass_code |
| cfg_bypass_code | input | 8 | Direct DAC value used in bypass |
| adc_data | input | 12 | Output-voltage sample |
| adc_valid | input | 1 | adc_data is a new sample |
| dac_code | output | 8 | Trim DAC code |

## Verification
The in-RTL assertions check these properties on every cycle:
- Every change of the code is a single-LSB step.
- The code never wraps at 0 or 255.
- The code stays still between ticks, and at ticks that have no fresh sample.
- The VID setpoint stays still without a strobe.
- Select 11 freezes the active setpoint.
- Bypass forwards its configured code.

Some behaviour only the directed scenarios can show, because it depends on input history and not on one cycle:
- The table values reached through strobes.
- The measured tick period at each rate.
- The direction chosen under each polarity.
- Convergence toward a newly strobed target.
- Where the loop resumes after bypass.

// File: rtl/vtrim_pkg.sv
package vtrim_pkg;
  localparam int unsigned SP_W  = 12;
  localparam int unsigned DAC_W = 8;

  typedef enum logic [1:0] {DIR_HOLD = 2'b00, DIR_UP = 2'b01, DIR_DN = 2'b10} dir_e;

  // Three-state compare: UP means the output voltage must rise.
  function automatic dir_e compare3(input logic [SP_W-1:0] target, input logic [SP_W-1:0] meas);
    if (meas < target)      return DIR_UP;
    else if (meas > target) return DIR_DN;
    else                    return DIR_HOLD;
  endfunction

  // One-LSB step with saturation; invert flips the code direction.
  function automatic logic [DAC_W-1:0] step_code(input logic [DAC_W-1:0] code, input dir_e dir,
                                                 input logic invert);
    logic inc, dec;
    inc = invert ? (dir == DIR_DN) : (dir == DIR_UP);
    dec = invert ? (dir == DIR_UP) : (dir == DIR_DN);
    if (inc && code != {DAC_W{1'b1}})      return code + 1'b1;
    else if (dec && code != '0)            return code - 1'b1;
    else                                   return code;
  endfunction

  function automatic logic [SP_W-1:0] vid_entry(input int unsigned code, input int unsigned base,
                                                input int unsigned step);
    int unsigned v;
    v = base + code * step;
    return v[SP_W-1:0];
  endfunction

  function automatic int unsigned tick_period(input int unsigned unit, input logic [1:0] rate);
    return unit << rate;
  endfunction
endpackage

// File: rtl/vtrim_setpoint.sv
module vtrim_setpoint
  import vtrim_pkg::*;
#(
  parameter int unsigned VID_W    = 4,
  parameter int unsigned VID_BASE = 32'h400,
  parameter int unsigned VID_STEP = 32'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] vid_code,
  input  logic             vid_strobe,
  input  logic [1:0]       prof_sel,
  input  logic [SP_W-1:0]  prof1,
  input  logic [SP_W-1:0]  prof2,
  output logic [SP_W-1:0]  vid_sp,
  output logic [SP_W-1:0]  active_sp
);
  localparam int unsigned N_VID = 1 << VID_W;

  logic [SP_W-1:0] table_q [N_VID];
  for (genvar g = 0; g < N_VID; g++) begin : g_tbl
    assign table_q[g] = vid_entry(g, VID_BASE, VID_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vid_sp <= '0;
    else if (vid_strobe) vid_sp <= table_q[vid_code];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_sp <= '0;
    else begin
      unique case (prof_sel)
        2'b00:   active_sp <= vid_sp;
        2'b01:   active_sp <= prof1;
        2'b10:   active_sp <= prof2;
        default: active_sp <= active_sp;
      endcase
    end
  end

  // R2: the VID setpoint moves only on a strobe
  a_r2_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_strobe |=> $stable(vid_sp));
  // R4: select 11 freezes the active setpoint
  a_r4_hold_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_sel == 2'b11) |=> $stable(active_sp));
endmodule

// File: rtl/vtrim_pace.sv
module vtrim_pace
  import vtrim_pkg::*;
#(
  parameter int unsigned RATE_UNIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      rate_sel,
  input  logic [SP_W-1:0] adc_data,
  input  logic            adc_valid,
  output logic            tick,
  output logic            fresh,
  output logic [SP_W-1:0] sample
);
  localparam int unsigned MAX_PER = RATE_UNIT << 3;
  localparam int unsigned CNT_W   = $clog2(MAX_PER) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'(tick_period(RATE_UNIT, rate_sel) - 1);
  assign tick     = (cnt_q >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // A sample in a tick cycle belongs to the next interval.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh  <= 1'b0;
      sample <= '0;
    end else begin
      if (adc_valid) sample <= adc_data;
      if (tick)           fresh <= adc_valid;
      else if (adc_valid) fresh <= 1'b1;
    end
  end

  // R5: no interval runs longer than the longest period
  a_r5_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_PER));
endmodule

// File: rtl/vtrim_stepper.sv
module vtrim_stepper
  import vtrim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fresh,
  input  logic [SP_W-1:0]  sample,
  input  logic [SP_W-1:0]  target,
  input  logic             invert,
  input  logic             bypass,
  input  logic [DAC_W-1:0] bypass_code,
  output logic [DAC_W-1:0] dac_q
);
  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};
  localparam logic [DAC_W-1:0] TOP = {DAC_W{1'b1}};

  dir_e dir;
  logic act;

  assign dir = compare3(target, sample);
  assign act = tick && fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_q <= MID;
    else if (bypass) dac_q <= bypass_code;
    else if (act)    dac_q <= step_code(dac_q, dir, invert);
  end

  // R6: closed-loop changes are single-LSB
  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |=> (dac_q == $past(dac_q) || dac_q == $past(dac_q) + 1'b1 ||
                 dac_q == $past(dac_q) - 1'b1));
  // R8: no wrap at either end
  a_r8_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && dac_q == TOP) |=> dac_q != '0);
  a_r8_no_wrap_bot: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && dac_q == '0) |=> dac_q != TOP);
  // R5: code is still between ticks
  a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !tick) |=> $stable(dac_q));
  // R9: no fresh sample, no step
  a_r9_stale_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !fresh) |=> $stable(dac_q));
  // R10: bypass forwards its code
  a_r10_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> dac_q == $past(bypass_code));
endmodule

// File: rtl/vtrim_loop.sv
module vtrim_loop
  import vtrim_pkg::*;
#(
  parameter int unsigned VID_W     = 4,
  parameter int unsigned VID_BASE  = 32'h400,
  parameter int unsigned VID_STEP  = 32'h20,
  parameter int unsigned RATE_UNIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] vid_code,
  input  logic             vid_strobe,
  input  logic [1:0]       prof_sel,
  input  logic [11:0]      cfg_profile1,
  input  logic [11:0]      cfg_profile2,
  input  logic [1:0]       cfg_rate,
  input  logic             cfg_invert,
  input  logic             cfg_bypass,
  input  logic [7:0]       cfg_bypass_code,
  input  logic [11:0]      adc_data,
  input  logic             adc_valid,
  output logic [7:0]       dac_code
);
  logic [SP_W-1:0] vid_sp, active_sp, sample;
  logic            tick, fresh;

  vtrim_setpoint #(.VID_W(VID_W), .VID_BASE(VID_BASE), .VID_STEP(VID_STEP)) u_sp (
    .clk, .rst_n, .vid_code, .vid_strobe, .prof_sel,
    .prof1(cfg_profile1), .prof2(cfg_profile2), .vid_sp, .active_sp);

  vtrim_pace #(.RATE_UNIT(RATE_UNIT)) u_pace (
    .clk, .rst_n, .rate_sel(cfg_rate), .adc_data, .adc_valid, .tick, .fresh, .sample);

  vtrim_stepper u_step (
    .clk, .rst_n, .tick, .fresh, .sample, .target(active_sp), .invert(cfg_invert),
    .bypass(cfg_bypass), .bypass_code(cfg_bypass_code), .dac_q(dac_code));
endmodule

// File: tb/vtrim_loop_bench.sv
module vtrim_loop_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  vid_code = '0;
  logic        vid_strobe = 1'b0;
  logic [1:0]  prof_sel = '0;
  logic [11:0] cfg_profile1 = '0, cfg_profile2 = '0, adc_data = '0;
  logic [1:0]  cfg_rate = '0;
  logic        cfg_invert = 1'b0, cfg_bypass = 1'b0, adc_valid = 1'b0;
  logic [7:0]  cfg_bypass_code = '0;
  logic [7:0]  dac_code;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vtrim_loop u_vtrim_loop (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int vid_val(input int c);
    return 'h400 + 'h20 * c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vid_strobe = 0; prof_sel = 0; cfg_rate = 0; cfg_invert = 0; cfg_bypass = 0;
    adc_valid = 0; adc_data = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic observe(input int n, output int ups, output int dns, output int big);
    logic [7:0] prev;
    ups = 0; dns = 0; big = 0;
    prev = dac_code;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dac_code == prev + 8'd1 && prev != 8'hFF) ups++;
      else if (dac_code == prev - 8'd1 && prev != 8'h00) dns++;
      else if (dac_code != prev) big++;
      prev = dac_code;
    end
  endtask

  task automatic t_reset();
    int u, d, b;
    do_reset();
    chk(dac_code == 8'h80, "R1 reset code", dac_code, 'h80);
    adc_valid = 1; adc_data = 0;
    observe(40, u, d, b);
    chk(u + d + b == 0, "R1 zero setpoint hold", u + d + b, 0);
  endtask

  task automatic t_period(input logic [1:0] r);
    int c;
    logic [7:0] p;
    do_reset();
    cfg_rate = r; prof_sel = 2'b01; cfg_profile1 = 12'hFFF; adc_data = 0; adc_valid = 1;
    p = dac_code;
    c = 0;
    while (dac_code == p && c < 100) begin @(negedge clk); c++; end
    p = dac_code; c = 0;
    while (dac_code == p && c < 100) begin @(negedge clk); c++; end
    chk(c == (4 << r), "R5 tick period", c, 4 << r);
    chk(dac_code == p + 8'd1, "R6 single up step", dac_code, p + 1);
  endtask

  task automatic t_polarity();
    int u, d, b;
    do_reset();
    prof_sel = 2'b01; cfg_profile1 = 12'h800; adc_data = 12'h700; adc_valid = 1;
    cfg_invert = 1;
    observe(40, u, d, b);
    chk(d >= 8 && u == 0 && b == 0, "R7 inverted raise decrements", d, 10);
    cfg_invert = 0;
    observe(40, u, d, b);
    chk(u >= 8 && d == 0 && b == 0, "R7 normal raise increments", u, 10);
    adc_data = 12'h900;
    repeat (3) @(negedge clk);
    observe(40, u, d, b);
    chk(d >= 8 && u == 0, "R6 high sample lowers", d, 10);
    adc_data = 12'h800;
    repeat (5) @(negedge clk);
    observe(40, u, d, b);
    chk(u + d + b == 0, "R6 equal holds", u + d + b, 0);
  endtask

  task automatic t_saturate();
    int u, d, b;
    do_reset();
    prof_sel = 2'b01; cfg_profile1 = 12'hFFF; adc_valid = 1;
    observe(700, u, d, b);
    chk(dac_code == 8'hFF && b == 0 && d == 0, "R8 top saturation", dac_code, 'hFF);
    prof_sel = 2'b00; adc_data = 12'hFFF;
    observe(1200, u, d, b);
    chk(dac_code == 8'h00 && b == 0 && u == 0, "R8 bottom saturation", dac_code, 0);
  endtask

  task automatic t_stale();
    int u, d, b;
    do_reset();
    prof_sel = 2'b01; cfg_profile1 = 12'hFFF; adc_data = 12'h100; adc_valid = 0;
    observe(40, u, d, b);
    chk(u + d + b == 0, "R9 no sample no step", u + d + b, 0);
    adc_valid = 1; @(negedge clk); adc_valid = 0;
    observe(40, u, d, b);
    chk(u == 1 && d + b == 0, "R9 one sample one step", u, 1);
  endtask

  task automatic t_vid();
    int u, d, b;
    do_reset();
    vid_code = 4'd3; vid_strobe = 1; adc_data = vid_val(3); adc_valid = 1;
    @(negedge clk); vid_strobe = 0;
    repeat (3) @(negedge clk);
    observe(40, u, d, b);
    chk(u + d + b == 0, "R2 table entry 3 matched", u + d + b, 0);
    vid_code = 4'd7;
    observe(40, u, d, b);
    chk(u + d + b == 0, "R2 code change without strobe", u + d + b, 0);
    vid_strobe = 1; @(negedge clk); vid_strobe = 0;
    observe(40, u, d, b);
    chk(u >= 8 && d + b == 0, "R11 steps toward new target", u, 10);
    adc_data = vid_val(7);
    repeat (5) @(negedge clk);
    observe(40, u, d, b);
    chk(u + d + b == 0, "R2 table entry 7 matched", u + d + b, 0);
  endtask

  task automatic t_profiles();
    int u, d, b;
    do_reset();
    prof_sel = 2'b01; cfg_profile1 = 12'h800; adc_data = 12'h800; adc_valid = 1;
    repeat (3) @(negedge clk);
    observe(40, u, d, b);
    chk(u + d + b == 0, "R3 profile1 selected", u + d + b, 0);
    prof_sel = 2'b11; cfg_profile1 = 12'h100;
    repeat (3) @(negedge clk);
    observe(40, u, d, b);
    chk(u + d + b == 0, "R4 select 11 holds", u + d + b, 0);
    prof_sel = 2'b01;
    observe(40, u, d, b);
    chk(d >= 8 && u + b == 0, "R3 profile1 new value", d, 10);
    prof_sel = 2'b10; cfg_profile2 = 12'hA00;
    observe(40, u, d, b);
    chk(u >= 8 && d + b == 0, "R3 profile2 selected", u, 10);
  endtask

  task automatic t_bypass();
    int u, d, b;
    do_reset();
    prof_sel = 2'b01; cfg_profile1 = 12'hFFF; adc_valid = 1;
    cfg_bypass = 1; cfg_bypass_code = 8'h33;
    @(negedge clk);
    chk(dac_code == 8'h33, "R10 bypass value", dac_code, 'h33);
    repeat (20) @(negedge clk);
    chk(dac_code == 8'h33, "R10 bypass held", dac_code, 'h33);
    cfg_bypass = 0;
    observe(5, u, d, b);
    chk(dac_code == 8'h34 && u == 1, "R10 loop resumes", dac_code, 'h34);
  endtask

  initial begin
    t_reset();
    for (int r = 0; r < 4; r++) t_period(r[1:0]);
    t_polarity();
    t_saturate();
    t_stale();
    t_vid();
    t_profiles();
    t_bypass();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule